// File: doc/BRIEF.md
# Audio Descriptor-Ring DMA Channel

This block is a single audio DMA channel that moves 32-bit sample words between system memory and a codec sample FIFO. Software places a table of descriptors in memory and writes the table address into the channel. It then sets the run bits in the command register. From that point the channel reads each descriptor itself, streams the region the descriptor names, and moves on to the next descriptor.

Each descriptor can do one of three things besides moving data. It can raise an end-of-page event and carry on. It can mark the end of the table and stop the channel. It can redirect the fetch to another descriptor address, which closes the table into a ring so that playback or capture loops with no processor help. A pause holds the transfer in place. Disabling the channel returns it to the table start. The current memory address can be read back at any time.

Top module: `audio_prd_dma`

## Requirements
- R1: Register index 0 is command, 1 is status, 2 is table base and 3 is the current pointer. After reset, command, status and pointer read 0, `irq` is low and no memory or FIFO request is active.
- R2: A descriptor is two words at consecutive word addresses. The first word is the region base. The second word is the size word: bits 16:0 hold the byte count, bit 31 marks end of table, bit 30 marks end of page and bit 29 marks a jump.
- R3: With command bit 3 at 0, the region's words are read from ascending addresses and pushed to the codec FIFO in that order. No word is pushed while `fifo_full` is high.
- R4: With command bit 3 at 1, words popped from the codec FIFO are written to ascending region addresses. No word is popped while `fifo_empty` is high.
- R5: Command bit 2 at 1 reverses the byte order of every word moved, in either direction. At 0 the words pass unchanged.
- R6: When a region whose end-of-page flag is set completes, status bit 0 and `irq` rise and the channel goes on to the next descriptor. A region without the flag leaves the status at 0.
- R7: When a region whose end-of-table flag is set completes, the run bits (command 1:0) read 00 and no further request is made.
- R8: A jump descriptor makes its base word the address of the next descriptor fetched, and it moves no data.
- R9: Run bits 11 pause the channel: no request is made and the pointer holds. Writing 01 resumes with the next word of the same region.
- R10: Run bits 00 stop the channel. The next enable restarts the fetch from the table base, not from the point where the channel stopped.
- R11: Reading the status register clears it, and `irq` then falls.
- R12: A non-jump descriptor with a byte count of 0 sets status bit 1 and clears the run bits to 00.
- R13: The pointer register holds the address of the next word to move. It grows by 4 on every word moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status when index 1) |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | High while any status bit is set |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_ack | input | 1 | Read accepted, data valid this cycle |
| mem_rd_data | input | 32 | Memory read data |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_addr | output | 32 | Memory write byte address |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_ack | input | 1 | Write accepted this cycle |
| fifo_wr_en | output | 1 | Push a word to the codec FIFO |
| fifo_wr_data | output | 32 | Word pushed |
| fifo_full | input | 1 | Codec FIFO cannot accept a word |
| fifo_rd_en | output | 1 | Pop a word from the codec FIFO |
| fifo_rd_data | input | 32 | Head word of the codec FIFO (show-ahead) |
| fifo_empty | input | 1 | Codec FIFO has no word |

## Verification
Playback is run through a two-descriptor table under both byte orders. Each order is run twice: once with memory that answers at once and a FIFO that never fills, and once with both stalling on alternate cycles. This separates wrong ordering and wrong swapping from handshake slips, and a lost or doubled word shows up in the push count. Capture is run with a pause placed in the middle of a region, so a pointer that moves while paused, or a resume that skips a word, both show up. A ring of one data descriptor and one jump is stopped at a set push count and then disabled and re-enabled. The first word after the restart shows whether the fetch returned to the table base. A zero-length descriptor checks the error path.

// File: rtl/audio_prd_dma.sv
module audio_prd_dma #(
  parameter int CNT_W = 17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_ack,
  input  logic [31:0] mem_rd_data,
  output logic        mem_wr_req,
  output logic [31:0] mem_wr_addr,
  output logic [31:0] mem_wr_data,
  input  logic        mem_wr_ack,
  output logic        fifo_wr_en,
  output logic [31:0] fifo_wr_data,
  input  logic        fifo_full,
  output logic        fifo_rd_en,
  input  logic [31:0] fifo_rd_data,
  input  logic        fifo_empty
);
  localparam logic [1:0] A_CMD = 2'd0, A_STS = 2'd1, A_BASE = 2'd2, A_PTR = 2'd3;
  localparam int F_EOT = 31, F_EOP = 30, F_JMP = 29;

  typedef enum logic [1:0] {S_IDLE, S_DESC_LO, S_DESC_HI, S_MOVE} st_t;

  st_t              st;
  logic [7:0]       cmd;
  logic [1:0]       sts;
  logic [31:0]      tbl_base, desc_ptr, cur_addr, buf_base;
  logic [CNT_W-1:0] remain;
  logic             eop_f, eot_f;

  function automatic logic [31:0] order(input logic [31:0] d, input logic sw);
    return sw ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
  endfunction

  wire              run      = (cmd[1:0] == 2'b01);
  wire              to_mem   = cmd[3];
  wire              fetching = run && (st == S_DESC_LO || st == S_DESC_HI);
  wire              moving   = run && (st == S_MOVE);
  wire              rd_take  = mem_rd_req && mem_rd_ack;
  wire [CNT_W-1:0]  cnt      = mem_rd_data[CNT_W-1:0];
  wire              last     = (remain <= CNT_W'(4));
  wire              beat     = fifo_wr_en || fifo_rd_en;

  assign mem_rd_req   = fetching || (moving && !to_mem && !fifo_full);
  assign mem_rd_addr  = (st == S_MOVE)    ? cur_addr :
                        (st == S_DESC_HI) ? desc_ptr + 32'd4 : desc_ptr;
  assign fifo_wr_en   = moving && !to_mem && rd_take;
  assign fifo_wr_data = order(mem_rd_data, cmd[2]);

  assign mem_wr_req   = moving && to_mem && !fifo_empty;
  assign mem_wr_addr  = cur_addr;
  assign mem_wr_data  = order(fifo_rd_data, cmd[2]);
  assign fifo_rd_en   = mem_wr_req && mem_wr_ack;

  assign irq = |sts;

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = {24'd0, cmd};
      A_STS:   reg_rdata = {30'd0, sts};
      A_BASE:  reg_rdata = tbl_base;
      default: reg_rdata = cur_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cmd      <= '0;
      sts      <= '0;
      tbl_base <= '0;
      desc_ptr <= '0;
      cur_addr <= '0;
      buf_base <= '0;
      remain   <= '0;
      eop_f    <= 1'b0;
      eot_f    <= 1'b0;
    end else begin
      if (reg_rd && reg_addr == A_STS) sts <= '0;
      case (st)
        S_IDLE: if (run) begin
          desc_ptr <= tbl_base;
          st       <= S_DESC_LO;
        end
        S_DESC_LO: if (fetching && rd_take) begin
          buf_base <= mem_rd_data;
          st       <= S_DESC_HI;
        end
        S_DESC_HI: if (fetching && rd_take) begin
          if (mem_rd_data[F_JMP]) begin
            desc_ptr <= buf_base;
            st       <= S_DESC_LO;
          end else if (cnt == '0) begin
            sts[1]   <= 1'b1;
            cmd[1:0] <= 2'b00;
            st       <= S_IDLE;
          end else begin
            cur_addr <= buf_base;
            remain   <= cnt;
            eop_f    <= mem_rd_data[F_EOP];
            eot_f    <= mem_rd_data[F_EOT];
            desc_ptr <= desc_ptr + 32'd8;
            st       <= S_MOVE;
          end
        end
        S_MOVE: if (beat) begin
          cur_addr <= cur_addr + 32'd4;
          remain   <= remain - CNT_W'(4);
          if (last) begin
            if (eop_f) sts[0] <= 1'b1;
            if (eot_f) begin
              cmd[1:0] <= 2'b00;
              st       <= S_IDLE;
            end else begin
              st <= S_DESC_LO;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
      if (reg_wr) begin
        case (reg_addr)
          A_CMD: begin
            cmd <= reg_wdata[7:0];
            if (!reg_wdata[0]) st <= S_IDLE;
          end
          A_BASE:  tbl_base <= reg_wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/audio_prd_dma_chk.sv
module audio_prd_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [1:0]  run_bits,
  input logic [31:0] ptr,
  input logic        irq,
  input logic        mem_rd_req,
  input logic        mem_rd_ack,
  input logic        mem_wr_req,
  input logic        mem_wr_ack,
  input logic        fifo_wr_en,
  input logic        fifo_full,
  input logic        fifo_rd_en,
  input logic        fifo_empty
);
  p_push_not_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en |-> !fifo_full);

  p_pop_not_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> !fifo_empty);

  p_pause_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_bits == 2'b11) |-> (!mem_rd_req && !mem_wr_req));

  p_pause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_bits == 2'b11) |=> $stable(ptr));

  p_stop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[1:0] == 2'b00) |=> (!mem_rd_req && !mem_wr_req));

  p_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd1 && !mem_rd_ack && !mem_wr_ack) |=> !irq);

  p_ptr_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_en || fifo_rd_en) |=> (ptr == $past(ptr) + 32'd4));
endmodule

bind audio_prd_dma audio_prd_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .run_bits(cmd[1:0]), .ptr(cur_addr), .irq(irq),
  .mem_rd_req(mem_rd_req), .mem_rd_ack(mem_rd_ack), .mem_wr_req(mem_wr_req),
  .mem_wr_ack(mem_wr_ack), .fifo_wr_en(fifo_wr_en), .fifo_full(fifo_full),
  .fifo_rd_en(fifo_rd_en), .fifo_empty(fifo_empty)
);

// File: tb/tb_audio_prd_dma.sv
module tb_audio_prd_dma;
  localparam int CLK_P = 10;
  localparam logic [31:0] EOT = 32'h8000_0000, EOP = 32'h4000_0000, JMP = 32'h2000_0000;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq;
  logic mem_rd_req, mem_rd_ack, mem_wr_req, mem_wr_ack;
  logic [31:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;
  logic fifo_wr_en, fifo_full, fifo_rd_en, fifo_empty;
  logic [31:0] fifo_wr_data, fifo_rd_data;

  logic [31:0] mem [0:255];
  logic [31:0] cap [0:255];
  int push_n = 0, src_idx = 0, push_lim = 1000, src_lim = 0;
  int total = 0, bad = 0;
  logic [7:0] tick = 0;
  logic ack_mode = 0, stall_mode = 0;
  logic tb_we = 0;
  logic [31:0] tb_wa = 0, tb_wd = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A00, ~a[15:0]};
  endfunction
  function automatic logic [31:0] srcw(input int k);
    return 32'hC0DE_0000 ^ (32'(k) * 32'h0101_0101);
  endfunction
  function automatic logic [31:0] bswap(input logic [31:0] d, input logic sw);
    return sw ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
  endfunction

  assign mem_rd_data  = mem[mem_rd_addr[9:2]];
  assign mem_rd_ack   = mem_rd_req && (!ack_mode || tick[0]);
  assign mem_wr_ack   = mem_wr_req && (!ack_mode || tick[0]);
  assign fifo_full    = (push_n >= push_lim) || (stall_mode && tick[1]);
  assign fifo_empty   = (src_idx >= src_lim) || (stall_mode && tick[1]);
  assign fifo_rd_data = srcw(src_idx);

  always @(posedge clk) begin
    tick <= tick + 8'd1;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(32'(i * 4));
    end else begin
      if (tb_we) mem[tb_wa[9:2]] <= tb_wd;
      if (mem_wr_req && mem_wr_ack) mem[mem_wr_addr[9:2]] <= mem_wr_data;
    end
    if (fifo_wr_en) begin
      cap[push_n % 256] <= fifo_wr_data;
      push_n <= push_n + 1;
    end
    if (fifo_rd_en) src_idx <= src_idx + 1;
  end

  audio_prd_dma dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack), .fifo_wr_en(fifo_wr_en),
    .fifo_wr_data(fifo_wr_data), .fifo_full(fifo_full), .fifo_rd_en(fifo_rd_en),
    .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); tb_we = 1; tb_wa = a; tb_wd = d;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic setdesc(input logic [31:0] slot, input logic [31:0] base, input logic [31:0] size);
    poke(slot, base);
    poke(slot + 4, size);
  endtask

  task automatic wait_stop();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd0, v);
      if (v[1:0] == 2'b00) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, p1, p2;
    int s, k1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(irq == 0 && !mem_rd_req && !mem_wr_req && !fifo_wr_en && !fifo_rd_en, "R1 idle", {28'd0, irq, mem_rd_req, mem_wr_req, fifo_wr_en}, 0);
    rd(2'd0, v); chk(v == 0, "R1 cmd", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 sts", v, 0);
    rd(2'd3, v); chk(v == 0, "R1 ptr", v, 0);

    // playback sweep: byte order x handshake pattern (R2 R3 R5 R6 R7 R11 R13)
    for (int sw = 0; sw < 2; sw++) begin
      for (int md = 0; md < 2; md++) begin
        ack_mode = md[0]; stall_mode = md[0];
        push_lim = push_n + 1000;
        setdesc(32'h100, 32'h200, 32'd16 | EOP);
        setdesc(32'h108, 32'h240, 32'd8 | EOP | EOT);
        s = push_n;
        wr(2'd2, 32'h100);
        wr(2'd0, sw[0] ? 32'h05 : 32'h01);
        wait_stop();
        chk(push_n - s == 6, "R7 word count", 32'(push_n - s), 6);
        for (int k = 0; k < 6; k++) begin
          logic [31:0] a;
          a = (k < 4) ? 32'h200 + 32'(4 * k) : 32'h240 + 32'(4 * (k - 4));
          chk(cap[(s + k) % 256] == bswap(pat(a), sw[0]), "R2 R3 R5 play word", cap[(s + k) % 256], bswap(pat(a), sw[0]));
        end
        rd(2'd3, v); chk(v == 32'h248, "R13 final ptr", v, 32'h248);
        rd(2'd0, v); chk(v[1:0] == 2'b00, "R7 run bits", v, 0);
        @(negedge clk); chk(irq == 1, "R6 irq", {31'd0, irq}, 1);
        rd(2'd1, v); chk(v == 1, "R6 eop status", v, 1);
        rd(2'd1, v); chk(v == 0, "R11 cleared", v, 0);
        @(negedge clk); chk(irq == 0, "R11 irq low", {31'd0, irq}, 0);
      end
    end

    // capture with pause, both byte orders (R4 R5 R9 R13)
    for (int sw = 0; sw < 2; sw++) begin
      ack_mode = 1; stall_mode = 0;
      s = src_idx;
      src_lim = s + 8;
      setdesc(32'h180, 32'h300, 32'd32 | EOT);
      wr(2'd2, 32'h180);
      wr(2'd0, sw[0] ? 32'h0D : 32'h09);
      if (sw == 0) begin
        repeat (6) @(negedge clk);
        wr(2'd0, 32'h0B);
        rd(2'd3, p1); k1 = src_idx;
        repeat (20) @(negedge clk);
        rd(2'd3, p2);
        chk(p1 == p2, "R9 ptr held", p2, p1);
        chk(src_idx == k1, "R9 no pops", 32'(src_idx), 32'(k1));
        chk(p1 == 32'h300 + 32'(4 * (k1 - s)) && p1 < 32'h320, "R9 R13 mid ptr", p1, 32'h300 + 32'(4 * (k1 - s)));
        wr(2'd0, 32'h09);
      end
      wait_stop();
      chk(src_idx - s == 8, "R4 pop count", 32'(src_idx - s), 8);
      for (int k = 0; k < 8; k++)
        chk(mem[(32'h300 >> 2) + k] == bswap(srcw(s + k), sw[0]), "R4 R5 rec word", mem[(32'h300 >> 2) + k], bswap(srcw(s + k), sw[0]));
      rd(2'd1, v); chk(v == 0, "R6 no eop no status", v, 0);
    end

    // ring via jump, then stop and restart (R8 R10)
    ack_mode = 0; stall_mode = 0;
    setdesc(32'h100, 32'h200, 32'd8 | EOP);
    setdesc(32'h108, 32'h100, JMP);
    s = push_n;
    push_lim = s + 3;
    wr(2'd2, 32'h100);
    wr(2'd0, 32'h01);
    repeat (40) @(negedge clk);
    chk(push_n - s == 3, "R8 ring count", 32'(push_n - s), 3);
    chk(cap[(s + 2) % 256] == pat(32'h200), "R8 wrapped word", cap[(s + 2) % 256], pat(32'h200));
    rd(2'd3, v); chk(v == 32'h204, "R13 ring ptr", v, 32'h204);
    rd(2'd1, v); chk(v == 1, "R6 ring eop", v, 1);
    wr(2'd0, 32'h00);
    rd(2'd0, v); chk(v[1:0] == 0, "R10 stopped", v, 0);
    push_lim = push_n + 1;
    wr(2'd0, 32'h01);
    repeat (20) @(negedge clk);
    chk(push_n - s == 4, "R10 one more", 32'(push_n - s), 4);
    chk(cap[(s + 3) % 256] == pat(32'h200), "R10 restart at base", cap[(s + 3) % 256], pat(32'h200));
    wr(2'd0, 32'h00);
    rd(2'd1, v);

    // zero-length error (R12)
    setdesc(32'h180, 32'h200, EOP);
    wr(2'd2, 32'h180);
    wr(2'd0, 32'h01);
    repeat (10) @(negedge clk);
    rd(2'd0, v); chk(v[1:0] == 0, "R12 run cleared", v, 0);
    rd(2'd1, v); chk(v == 2, "R12 error bit", v, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule